// File: doc/BRIEF.md
# Command-Driven Register Load Unit

This unit sits behind a GPU command parser and executes register-load commands that have already been decoded. Each command names a target by byte address and supplies the value in one of two ways. The value can come straight from the command as an immediate word. It can also come from memory: the unit then issues a single-word read on a simple request/valid port and writes the word that comes back. A small set of state registers is held here: five draw parameters, three compute dispatch dimensions and a 16-bit blitter control word. All of them are driven out continuously to the consumers.

The blitter control word does not take a plain overwrite. The upper half of the written word names bits to clear, and the lower half names bits to set. The clear is applied first, so a bit that is both cleared and set ends up set. Addresses outside the map are dropped quietly. A one-cycle strobe reports every committed write together with its address, whether or not that address was mapped.

Top module: `reg_load_unit`

## Requirements
- R1: After reset every state output is zero, and `busy_o`, `mem_req_o` and `wr_stb_o` are low.
- R2: Draw parameters are mapped as follows: byte address 0x2430 loads start vertex, 0x2434 loads vertex count, 0x2438 loads instance count, 0x243C loads start instance and 0x2440 loads base vertex.
- R3: Byte addresses 0x2500, 0x2504 and 0x2508 load the X, Y and Z dispatch dimensions.
- R4: A write of word w to 0x22200 sets the blitter control to (old AND NOT w[31:16]) OR w[15:0]. A bit that is named in both halves ends up set.
- R5: A write to 0x2420, or to any address not listed in R2 to R4, changes no state output but still pulses `wr_stb_o` with that address.
- R6: An immediate command (`cmd_mem_i`=0) accepted while idle commits `cmd_data_i` on that clock edge. One cycle later, `wr_stb_o` is high for exactly one cycle with `wr_addr_o` equal to `cmd_addr_i`, and the new value is visible on the outputs.
- R7: A memory command (`cmd_mem_i`=1) accepted while idle raises `busy_o` and `mem_req_o` from the next cycle, with `mem_addr_o` holding `cmd_mem_addr_i`. Both stay high until `mem_rvalid_i` is seen.
- R8: On the edge where `mem_rvalid_i` is high while busy, `mem_rdata_i` is written to the latched address. `busy_o` and `mem_req_o` then drop, and the strobe follows as in R6.
- R9: Any command presented while `busy_o` is high is ignored, and this includes the cycle in which `mem_rvalid_i` arrives.
- R10: For a memory command, `cmd_data_i` has no effect on the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_mem_i | input | 1 | 0 = immediate value, 1 = value from memory |
| cmd_addr_i | input | 32 | Target register byte address |
| cmd_data_i | input | 32 | Immediate value |
| cmd_mem_addr_i | input | 64 | Memory address for the memory form |
| busy_o | output | 1 | Waiting for read data; commands ignored |
| mem_req_o | output | 1 | Read request, held until data returns |
| mem_addr_o | output | 64 | Read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| wr_stb_o | output | 1 | One-cycle pulse per committed write |
| wr_addr_o | output | 32 | Address of the committed write |
| start_vertex_o | output | 32 | Start vertex |
| vertex_count_o | output | 32 | Vertex count |
| instance_count_o | output | 32 | Instance count |
| start_instance_o | output | 32 | Start instance |
| base_vertex_o | output | 32 | Base vertex |
| dim_x_o | output | 32 | Dispatch dimension X |
| dim_y_o | output | 32 | Dispatch dimension Y |
| dim_z_o | output | 32 | Dispatch dimension Z |
| blt_ctrl_o | output | 16 | Blitter control bits |

## Verification
Two events can land on the same edge: a memory read returning and committing its write, and a new command arriving from the parser. The bench provokes this by raising `cmd_valid_i` with an immediate command in the exact cycle it asserts `mem_rvalid_i`. It judges the result through the scoreboard. Only the memory write may produce a strobe and a register change, so the colliding command must leave no trace on the outputs. Within a single blitter write, clear and set on the same bit also coincide, and the bench checks that the set wins.

// File: rtl/rlu_pkg.sv
package rlu_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned MADDR_W = 64;
  localparam int unsigned HALF_W  = DATA_W / 2;

  localparam logic [ADDR_W-1:0] A_END_OFS    = 32'h0000_2420;
  localparam logic [ADDR_W-1:0] A_START_VTX  = 32'h0000_2430;
  localparam logic [ADDR_W-1:0] A_VTX_CNT    = 32'h0000_2434;
  localparam logic [ADDR_W-1:0] A_INST_CNT   = 32'h0000_2438;
  localparam logic [ADDR_W-1:0] A_START_INST = 32'h0000_243C;
  localparam logic [ADDR_W-1:0] A_BASE_VTX   = 32'h0000_2440;
  localparam logic [ADDR_W-1:0] A_DIM_X      = 32'h0000_2500;
  localparam logic [ADDR_W-1:0] A_DIM_Y      = 32'h0000_2504;
  localparam logic [ADDR_W-1:0] A_DIM_Z      = 32'h0000_2508;
  localparam logic [ADDR_W-1:0] A_BLT_CTRL   = 32'h0002_2200;

  localparam int unsigned NUM_PLAIN = 8;
  localparam int unsigned NUM_REGS  = NUM_PLAIN + 1;
  localparam int unsigned IDX_BLT   = NUM_PLAIN;
  localparam int unsigned IDX_W     = $clog2(NUM_REGS + 1);

  typedef enum logic {S_IDLE, S_WAIT} seq_state_e;

  // Index NUM_REGS means "no register" (accepted but dropped)
  function automatic logic [IDX_W-1:0] reg_index(input logic [ADDR_W-1:0] a);
    logic [IDX_W-1:0] r;
    unique case (a)
      A_START_VTX:  r = IDX_W'(0);
      A_VTX_CNT:    r = IDX_W'(1);
      A_INST_CNT:   r = IDX_W'(2);
      A_START_INST: r = IDX_W'(3);
      A_BASE_VTX:   r = IDX_W'(4);
      A_DIM_X:      r = IDX_W'(5);
      A_DIM_Y:      r = IDX_W'(6);
      A_DIM_Z:      r = IDX_W'(7);
      A_BLT_CTRL:   r = IDX_W'(IDX_BLT);
      default:      r = IDX_W'(NUM_REGS);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rlu_seq.sv
module rlu_seq
  import rlu_pkg::*;
#(
  parameter int unsigned AW  = ADDR_W,
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned MAW = MADDR_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cmd_valid_i,
  input  logic           cmd_mem_i,
  input  logic [AW-1:0]  cmd_addr_i,
  input  logic [DW-1:0]  cmd_data_i,
  input  logic [MAW-1:0] cmd_mem_addr_i,
  input  logic           mem_rvalid_i,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic           busy_o,
  output logic [MAW-1:0] mem_addr_o,
  output logic           commit_o,
  output logic [AW-1:0]  commit_addr_o,
  output logic [DW-1:0]  commit_data_o
);
  seq_state_e    state_q;
  logic [AW-1:0] held_addr_q;
  logic [MAW-1:0] mem_addr_q;
  logic accept;

  assign accept = (state_q == S_IDLE) && cmd_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      held_addr_q <= '0;
      mem_addr_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (accept && cmd_mem_i) begin
          state_q     <= S_WAIT;
          held_addr_q <= cmd_addr_i;
          mem_addr_q  <= cmd_mem_addr_i;
        end
        S_WAIT: if (mem_rvalid_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o        = (state_q == S_WAIT);
  assign mem_addr_o    = mem_addr_q;
  assign commit_o      = (accept && !cmd_mem_i) || (busy_o && mem_rvalid_i);
  assign commit_addr_o = busy_o ? held_addr_q : cmd_addr_i;
  assign commit_data_o = busy_o ? mem_rdata_i : cmd_data_i;
endmodule

// File: rtl/rlu_decode.sv
module rlu_decode
  import rlu_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned NR = NUM_REGS
) (
  input  logic [AW-1:0] addr_i,
  output logic [NR-1:0] sel_o
);
  logic [IDX_W-1:0] idx;
  assign idx = reg_index(addr_i);

  for (genvar g = 0; g < NR; g++) begin : g_sel
    assign sel_o[g] = (idx == IDX_W'(g));
  end
endmodule

// File: rtl/rlu_regfile.sv
module rlu_regfile
  import rlu_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NP = NUM_PLAIN,
  parameter int unsigned HW = DW / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [NP:0]       sel_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [NP-1:0][DW-1:0] plain_o,
  output logic [HW-1:0]     blt_o
);
  for (genvar g = 0; g < NP; g++) begin : g_plain
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              q <= '0;
      else if (we_i && sel_i[g]) q <= wdata_i;
    end
    assign plain_o[g] = q;
  end

  // Clear bits named in the upper half first, then set those in the lower half
  logic [HW-1:0] blt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) blt_q <= '0;
    else if (we_i && sel_i[NP])
      blt_q <= (blt_q & ~wdata_i[DW-1:HW]) | wdata_i[HW-1:0];
  end
  assign blt_o = blt_q;
endmodule

// File: rtl/reg_load_unit.sv
module reg_load_unit
  import rlu_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  input  logic                cmd_mem_i,
  input  logic [ADDR_W-1:0]   cmd_addr_i,
  input  logic [DATA_W-1:0]   cmd_data_i,
  input  logic [MADDR_W-1:0]  cmd_mem_addr_i,
  output logic                busy_o,
  output logic                mem_req_o,
  output logic [MADDR_W-1:0]  mem_addr_o,
  input  logic                mem_rvalid_i,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  output logic                wr_stb_o,
  output logic [ADDR_W-1:0]   wr_addr_o,
  output logic [DATA_W-1:0]   start_vertex_o,
  output logic [DATA_W-1:0]   vertex_count_o,
  output logic [DATA_W-1:0]   instance_count_o,
  output logic [DATA_W-1:0]   start_instance_o,
  output logic [DATA_W-1:0]   base_vertex_o,
  output logic [DATA_W-1:0]   dim_x_o,
  output logic [DATA_W-1:0]   dim_y_o,
  output logic [DATA_W-1:0]   dim_z_o,
  output logic [HALF_W-1:0]   blt_ctrl_o
);
  logic              commit;
  logic [ADDR_W-1:0] commit_addr;
  logic [DATA_W-1:0] commit_data;
  logic [NUM_REGS-1:0] sel;
  logic [NUM_PLAIN-1:0][DATA_W-1:0] plain;

  rlu_seq u_seq (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_mem_i, .cmd_addr_i, .cmd_data_i,
    .cmd_mem_addr_i, .mem_rvalid_i, .mem_rdata_i,
    .busy_o, .mem_addr_o,
    .commit_o(commit), .commit_addr_o(commit_addr), .commit_data_o(commit_data)
  );

  rlu_decode u_dec (.addr_i(commit_addr), .sel_o(sel));

  rlu_regfile u_rf (
    .clk_i, .rst_ni, .we_i(commit), .sel_i(sel), .wdata_i(commit_data),
    .plain_o(plain), .blt_o(blt_ctrl_o)
  );

  assign mem_req_o = busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_stb_o  <= 1'b0;
      wr_addr_o <= '0;
    end else begin
      wr_stb_o <= commit;
      if (commit) wr_addr_o <= commit_addr;
    end
  end

  assign start_vertex_o   = plain[0];
  assign vertex_count_o   = plain[1];
  assign instance_count_o = plain[2];
  assign start_instance_o = plain[3];
  assign base_vertex_o    = plain[4];
  assign dim_x_o          = plain[5];
  assign dim_y_o          = plain[6];
  assign dim_z_o          = plain[7];
endmodule

// File: rtl/rlu_checker.sv
module rlu_checker
  import rlu_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cmd_valid_i,
  input logic               cmd_mem_i,
  input logic [ADDR_W-1:0]  cmd_addr_i,
  input logic [DATA_W-1:0]  cmd_data_i,
  input logic [MADDR_W-1:0] cmd_mem_addr_i,
  input logic               busy_o,
  input logic               mem_req_o,
  input logic [MADDR_W-1:0] mem_addr_o,
  input logic               mem_rvalid_i,
  input logic               wr_stb_o,
  input logic [ADDR_W-1:0]  wr_addr_o,
  input logic [DATA_W-1:0]  vertex_count_o,
  input logic [DATA_W-1:0]  dim_x_o,
  input logic [HALF_W-1:0]  blt_ctrl_o
);
  logic imm_acc, mem_acc;
  assign imm_acc = cmd_valid_i && !busy_o && !cmd_mem_i;
  assign mem_acc = cmd_valid_i && !busy_o && cmd_mem_i;

  p_imm_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imm_acc |=> wr_stb_o && (wr_addr_o == $past(cmd_addr_i)) && !busy_o);

  p_mem_request_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_acc |=> busy_o && mem_req_o && (mem_addr_o == $past(cmd_mem_addr_i)));

  p_wait_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mem_rvalid_i) |=> busy_o && mem_req_o && $stable(mem_addr_o));

  p_return_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mem_rvalid_i) |=> !busy_o && !mem_req_o && wr_stb_o);

  p_busy_no_strobe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mem_rvalid_i) |=> !wr_stb_o);

  p_blt_rule_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imm_acc && cmd_addr_i == A_BLT_CTRL) |=>
      blt_ctrl_o == (($past(blt_ctrl_o) & ~$past(cmd_data_i[DATA_W-1:HALF_W]))
                     | $past(cmd_data_i[HALF_W-1:0])));

  p_unmapped_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imm_acc && reg_index(cmd_addr_i) == IDX_W'(NUM_REGS)) |=>
      $stable(blt_ctrl_o) && $stable(vertex_count_o) && $stable(dim_x_o));
endmodule

bind reg_load_unit rlu_checker u_rlu_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_mem_i(cmd_mem_i),
  .cmd_addr_i(cmd_addr_i), .cmd_data_i(cmd_data_i), .cmd_mem_addr_i(cmd_mem_addr_i),
  .busy_o(busy_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
  .mem_rvalid_i(mem_rvalid_i), .wr_stb_o(wr_stb_o), .wr_addr_o(wr_addr_o),
  .vertex_count_o(vertex_count_o), .dim_x_o(dim_x_o), .blt_ctrl_o(blt_ctrl_o)
);

// File: tb/tb_reg_load_unit.sv
`timescale 1ns/1ps
module tb_reg_load_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_mem = 1'b0;
  logic [31:0] cmd_addr = '0, cmd_data = '0;
  logic [63:0] cmd_mem_addr = '0;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        busy, mem_req, wr_stb;
  logic [63:0] mem_addr;
  logic [31:0] wr_addr;
  logic [31:0] sv, vc, ic, si, bv, dx, dy, dz;
  logic [15:0] blt;

  always #4 clk = ~clk;

  reg_load_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_mem_i(cmd_mem),
    .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data), .cmd_mem_addr_i(cmd_mem_addr),
    .busy_o(busy), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .wr_stb_o(wr_stb), .wr_addr_o(wr_addr),
    .start_vertex_o(sv), .vertex_count_o(vc), .instance_count_o(ic),
    .start_instance_o(si), .base_vertex_o(bv), .dim_x_o(dx), .dim_y_o(dy),
    .dim_z_o(dz), .blt_ctrl_o(blt)
  );

  typedef struct { logic [31:0] addr; logic [8:0][31:0] regs; string tag; } item_t;
  item_t sb_q[$];
  logic [8:0][31:0] model = '0;
  int checks = 0, errors = 0;

  function automatic logic [8:0][31:0] observed();
    return {{16'h0, blt}, dz, dy, dx, bv, si, ic, vc, sv};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model of the register map and the blitter rule
  task automatic model_write(input logic [31:0] a, input logic [31:0] d, input string tag);
    item_t it;
    case (a)
      32'h2430: model[0] = d;
      32'h2434: model[1] = d;
      32'h2438: model[2] = d;
      32'h243C: model[3] = d;
      32'h2440: model[4] = d;
      32'h2500: model[5] = d;
      32'h2504: model[6] = d;
      32'h2508: model[7] = d;
      32'h22200: model[8] = {16'h0, (model[8][15:0] & ~d[31:16]) | d[15:0]};
      default: ;
    endcase
    it.addr = a; it.regs = model; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: every strobe must match the next expected item
  always @(negedge clk) begin
    if (rst_n && wr_stb) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R9 unexpected strobe", {32'h0, wr_addr}, 64'h0);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        chk(wr_addr == it.addr, {it.tag, " addr"}, {32'h0, wr_addr}, {32'h0, it.addr});
        for (int i = 0; i < 9; i++)
          chk(observed()[i] == it.regs[i], {it.tag, " reg"}, {32'h0, observed()[i]}, {32'h0, it.regs[i]});
      end
    end
  end

  task automatic imm_write(input logic [31:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_mem = 1'b0; cmd_addr = a; cmd_data = d;
    model_write(a, d, tag);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic mem_write(input logic [31:0] a, input logic [63:0] ma, input logic [31:0] rd,
                           input int lat, input bit collide);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_mem = 1'b1; cmd_addr = a; cmd_mem_addr = ma;
    cmd_data = 32'hDEAD_BEEF;  // must not be used (R10)
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy && mem_req, "R7 busy/req", {62'h0, busy, mem_req}, 64'h3);
    chk(mem_addr == ma, "R7 mem addr", mem_addr, ma);
    for (int i = 0; i < lat; i++) begin
      // stray command while busy must be dropped (R9)
      cmd_valid = 1'b1; cmd_mem = 1'b0; cmd_addr = 32'h2430; cmd_data = 32'h5555_0000 + i;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(busy && mem_req && mem_addr == ma, "R7 hold", {63'h0, busy}, 64'h1);
    end
    mem_rvalid = 1'b1; mem_rdata = rd;
    if (collide) begin
      cmd_valid = 1'b1; cmd_mem = 1'b0; cmd_addr = 32'h2504; cmd_data = 32'hBAD0_0001;
    end
    model_write(a, rd, "R8 mem write");
    @(negedge clk);
    mem_rvalid = 1'b0; cmd_valid = 1'b0;
    chk(!busy && !mem_req, "R8 release", {62'h0, busy, mem_req}, 64'h0);
  endtask

  initial begin
    #(8 * 200000);
    chk(1'b0, "watchdog", 64'h0, 64'h1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(observed() == '0, "R1 regs", {32'h0, observed()[0]}, 64'h0);
    chk(!busy && !mem_req && !wr_stb, "R1 ctrl", {61'h0, busy, mem_req, wr_stb}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    imm_write(32'h2430, 32'h0000_0011, "R2 start vertex");
    imm_write(32'h2434, 32'h0000_0222, "R2 vertex count");
    imm_write(32'h2438, 32'h0000_3333, "R2 instance count");
    imm_write(32'h243C, 32'h0004_4444, "R2 start instance");
    imm_write(32'h2440, 32'hFFFF_FFFB, "R2 base vertex");
    imm_write(32'h2500, 32'h0000_0040, "R3 dim x");
    imm_write(32'h2504, 32'h0000_0020, "R3 dim y");
    imm_write(32'h2508, 32'h0000_0001, "R3 dim z");
    imm_write(32'h2420, 32'h1234_5678, "R5 no-op address");
    imm_write(32'h0000_1234, 32'hFFFF_FFFF, "R5 unmapped");
    imm_write(32'h0002_2204, 32'hFFFF_FFFF, "R5 near blt");
    imm_write(32'h22200, 32'h0000_00FF, "R4 set");
    imm_write(32'h22200, 32'h000F_0F00, "R4 clear+set");
    imm_write(32'h22200, 32'h0001_0001, "R4 same bit set wins");
    imm_write(32'h22200, 32'hFFFF_0000, "R4 clear all");
    imm_write(32'h2434, 32'hA5A5_5A5A, "R6 overwrite");

    mem_write(32'h2434, 64'h0000_0001_0000_1000, 32'h0000_0777, 0, 1'b0);
    mem_write(32'h2508, 64'hFFFF_0000_8000_0004, 32'h0000_0009, 3, 1'b1);
    mem_write(32'h22200, 64'h0000_0000_0000_2000, 32'h0000_8001, 2, 1'b1);
    mem_write(32'h0000_3000, 64'h0000_0000_0000_3000, 32'hFFFF_FFFF, 1, 1'b0);
    imm_write(32'h2500, 32'h0000_0100, "R6 after mem");

    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R6 all strobes seen", 64'(sb_q.size()), 64'h0);
    chk(!wr_stb && !busy, "R9 idle at end", {62'h0, wr_stb, busy}, 64'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule